// File: doc/BRIEF.md
# External latch and buffer strobe generator

This block sits on a simple single-cycle host register bus and turns accesses to four fixed indices into control strobes for external byte or word latches (for output ports) and tristate buffers (for input ports). There are two port groups, A and B, each with a write index and a read index. A write to a group's write index stores the bus data in an internal shadow register and emits a single-cycle latch pulse. A read of a group's read index lowers an active-low buffer-enable strobe, asserts the device-select and acknowledge handshakes, and stops driving the block's own read data so the external buffer can put its value on the bus.

Each group has a strap input sampled while reset is asserted. A low strap puts the group's two pins in strobe mode. A high strap makes them plain general-purpose outputs that pass through values from elsewhere in the chip. Byte accesses use data lanes 23:16, and word accesses use lanes 31:16. The shadow registers can always be read back through the write indices.

Top module: `xlatch_strobe`

## Requirements
- R1: In strobe mode, a write to index 0xE0 (group A) or 0xF0 (group B) sampled at clock edge k drives `pin[0]` (A) or `pin[2]` (B) high for exactly the one cycle after edge k, with `ack` and `dev_sel` high in that same cycle.
- R2: In strobe mode, a read of index 0xE1 (A) or 0xF1 (B) sampled at edge k holds `pin[1]` (A) or `pin[3]` (B) low for the RD_WAIT cycles after edge k. `dev_sel` is high in all of those cycles, and `ack` is high only in the last of them.
- R3: A byte access (`wide`=0) moves data on `wdata[23:16]`/`rdata[23:16]` and writes only shadow bits 7:0. A word access (`wide`=1) moves data on lanes 31:16 and covers shadow bits 15:0. Unused read lanes are zero.
- R4: A read of a write index, or of a read index whose group is in GPIO mode, returns that group's shadow value with `ack`, `dev_sel` and `rd_drive` high in the cycle after the request.
- R5: While a strobe-mode read is in progress, `rd_drive` is low and `rdata` is zero.
- R6: A write to a read index is acknowledged in the next cycle, produces no strobe and leaves the shadow registers unchanged.
- R7: The straps are sampled while `rst_n` is low. For a group whose strap is high, its two pins follow `gpio_out` and its accesses produce no strobes; shadow writes still take place.
- R8: An access to any other index produces no strobe, ignores write data, and reads back zero with `ack` in the next cycle.
- R9: A request that arrives while a strobe-mode read is in progress is ignored.
- R10: No more than one strobe (latch pulse or buffer enable) is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; straps are sampled while low |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| wide | input | 1 | 1 = word access, 0 = byte access |
| addr | input | 8 | Register index |
| wdata | input | 32 | Write data bus |
| rdata | output | 32 | Read data, zero when not driven |
| rd_drive | output | 1 | High when the block drives `rdata` |
| dev_sel | output | 1 | Device-select handshake |
| ack | output | 1 | Ready handshake; the access completes in this cycle |
| strap_a_n | input | 1 | Group A strap, low = strobe mode |
| strap_b_n | input | 1 | Group B strap, low = strobe mode |
| gpio_out | input | 4 | Pin values used in GPIO mode |
| pin | output | 4 | {B read enable, B latch, A read enable, A latch} |

## Verification
Every single-cycle result (latch pulse, `ack`, `dev_sel`, readback data and drive) is due in the first cycle after the edge that samples the request. A buffer-enable strobe lasts RD_WAIT cycles, and its acknowledge arrives in the last of them. The bench drives requests on falling edges. A behavioural model advances on each rising edge, and every output is compared with the model on the following falling edge, so each result is checked in exactly the cycle it is due. Requests issued during a buffer read, straps changed across two resets, and byte and word patterns all go through the same per-cycle comparison.

// File: rtl/xlatch_strobe.sv
module xlatch_strobe #(
  parameter int          RD_WAIT = 2,
  parameter logic [7:0]  A_WR    = 8'hE0,
  parameter logic [7:0]  A_RD    = 8'hE1,
  parameter logic [7:0]  B_WR    = 8'hF0,
  parameter logic [7:0]  B_RD    = 8'hF1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic        wide,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        rd_drive,
  output logic        dev_sel,
  output logic        ack,
  input  logic        strap_a_n,
  input  logic        strap_b_n,
  input  logic [3:0]  gpio_out,
  output logic [3:0]  pin
);
  localparam int CW = $clog2(RD_WAIT + 1);

  logic          mode_a, mode_b;
  logic [15:0]   sh_a, sh_b;
  logic [CW-1:0] rd_cnt;
  logic          rd_grp;
  logic          lat_a, lat_b, one_ack, drive_q;
  logic [31:0]   rdata_q;

  wire hit_aw = addr == A_WR;
  wire hit_ar = addr == A_RD;
  wire hit_bw = addr == B_WR;
  wire hit_br = addr == B_RD;
  wire busy   = rd_cnt != '0;
  wire acc    = req && !busy;
  wire strobe_rd = acc && !we && ((hit_ar && mode_a) || (hit_br && mode_b));
  wire plain_rd  = acc && !we && !strobe_rd;

  wire [15:0] new_a = wide ? wdata[31:16] : {sh_a[15:8], wdata[23:16]};
  wire [15:0] new_b = wide ? wdata[31:16] : {sh_b[15:8], wdata[23:16]};
  wire [15:0] rb    = (hit_aw || hit_ar) ? sh_a : (hit_bw || hit_br) ? sh_b : 16'h0;
  wire [31:0] fmt   = wide ? {rb, 16'h0} : {8'h0, rb[7:0], 16'h0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_a  <= ~strap_a_n;
      mode_b  <= ~strap_b_n;
      sh_a    <= '0;
      sh_b    <= '0;
      rd_cnt  <= '0;
      rd_grp  <= 1'b0;
      lat_a   <= 1'b0;
      lat_b   <= 1'b0;
      one_ack <= 1'b0;
      drive_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (acc && we && hit_aw) sh_a <= new_a;
      if (acc && we && hit_bw) sh_b <= new_b;
      lat_a   <= acc && we && hit_aw && mode_a;
      lat_b   <= acc && we && hit_bw && mode_b;
      one_ack <= acc && !strobe_rd;
      drive_q <= plain_rd;
      rdata_q <= plain_rd ? fmt : 32'h0;
      if (strobe_rd) begin
        rd_cnt <= CW'(RD_WAIT);
        rd_grp <= hit_br;
      end else if (busy) begin
        rd_cnt <= rd_cnt - CW'(1);
      end
    end
  end

  wire oe_a_n = !(busy && !rd_grp);
  wire oe_b_n = !(busy && rd_grp);

  assign ack      = one_ack | (rd_cnt == CW'(1));
  assign dev_sel  = one_ack | busy;
  assign rd_drive = drive_q;
  assign rdata    = rdata_q;
  assign pin[0]   = mode_a ? lat_a  : gpio_out[0];
  assign pin[1]   = mode_a ? oe_a_n : gpio_out[1];
  assign pin[2]   = mode_b ? lat_b  : gpio_out[2];
  assign pin[3]   = mode_b ? oe_b_n : gpio_out[3];
endmodule

module xlatch_strobe_chk #(
  parameter logic [7:0] A_WR = 8'hE0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        we,
  input logic [7:0]  addr,
  input logic        busy,
  input logic        mode_a,
  input logic        mode_b,
  input logic        ack,
  input logic        dev_sel,
  input logic        rd_drive,
  input logic [31:0] rdata,
  input logic [3:0]  gpio_out,
  input logic [3:0]  pin
);
  p_latch_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a && pin[0]) |-> $past(req && we && addr == A_WR && !busy));

  p_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a && !pin[1]) |-> (dev_sel && !rd_drive && rdata == 32'h0));

  p_ack_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> dev_sel);

  p_oe_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b && !pin[3] && ack) |=> pin[3]);

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mode_a & pin[0], mode_a & ~pin[1], mode_b & pin[2], mode_b & ~pin[3]}));

  p_gpio_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_a |-> (pin[1:0] == gpio_out[1:0]));
endmodule

bind xlatch_strobe xlatch_strobe_chk #(.A_WR(A_WR)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .busy(busy),
  .mode_a(mode_a), .mode_b(mode_b), .ack(ack), .dev_sel(dev_sel),
  .rd_drive(rd_drive), .rdata(rdata), .gpio_out(gpio_out), .pin(pin)
);

// File: tb/tb_xlatch_strobe.sv
module tb_xlatch_strobe;
  localparam int RW = 2;

  logic clk = 0, rst_n = 0, req = 0, we = 0, wide = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0;
  logic strap_a_n = 0, strap_b_n = 0;
  logic [3:0] gpio_out = 0;
  logic [31:0] rdata;
  logic rd_drive, dev_sel, ack;
  logic [3:0] pin;

  xlatch_strobe #(.RD_WAIT(RW)) dut (.*);

  always #5 clk = ~clk;

  int vectors = 0, errors = 0;
  bit done = 0;

  // behavioural model state
  int m_rem = 0, m_grp = 0, sh_a = 0, sh_b = 0, m_rdata = 0;
  bit ma = 0, mb = 0, m_lat_a = 0, m_lat_b = 0, m_ack1 = 0, m_drv = 0;

  function automatic int lanes(int v, bit w);
    return w ? ((v & 'hFFFF) << 16) : ((v & 'hFF) << 16);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma = !strap_a_n; mb = !strap_b_n;
      m_rem = 0; sh_a = 0; sh_b = 0; m_lat_a = 0; m_lat_b = 0;
      m_ack1 = 0; m_drv = 0; m_rdata = 0;
    end else begin
      bit was_busy;
      was_busy = m_rem > 0;
      if (was_busy) m_rem--;
      m_lat_a = 0; m_lat_b = 0; m_ack1 = 0; m_drv = 0; m_rdata = 0;
      if (req && !was_busy) begin   // R9: ignored while busy
        if (we) begin
          m_ack1 = 1;
          if (addr == 8'hE0) begin
            sh_a = wide ? wdata[31:16] : ((sh_a & 'hFF00) | wdata[23:16]);
            m_lat_a = ma;
          end else if (addr == 8'hF0) begin
            sh_b = wide ? wdata[31:16] : ((sh_b & 'hFF00) | wdata[23:16]);
            m_lat_b = mb;
          end
        end else if ((addr == 8'hE1 && ma) || (addr == 8'hF1 && mb)) begin
          m_rem = RW; m_grp = (addr == 8'hF1);
        end else begin
          m_ack1 = 1; m_drv = 1;
          if (addr == 8'hE0 || addr == 8'hE1) m_rdata = lanes(sh_a, wide);
          else if (addr == 8'hF0 || addr == 8'hF1) m_rdata = lanes(sh_b, wide);
        end
      end
    end
  end

  task automatic cmp(string tag, string name, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit busy;
    logic [3:0] ep;
    busy = m_rem > 0;
    ep[0] = ma ? m_lat_a : gpio_out[0];
    ep[1] = ma ? !(busy && m_grp == 0) : gpio_out[1];
    ep[2] = mb ? m_lat_b : gpio_out[2];
    ep[3] = mb ? !(busy && m_grp == 1) : gpio_out[3];
    cmp("R1", "latch pins", {30'h0, pin[2], pin[0]}, {30'h0, ep[2], ep[0]});
    cmp("R2", "enable pins", {30'h0, pin[3], pin[1]}, {30'h0, ep[3], ep[1]});
    cmp("R2", "ack", ack, m_ack1 || m_rem == 1);
    cmp("R2", "dev_sel", dev_sel, m_ack1 || busy);
    cmp("R5", "rd_drive", rd_drive, m_drv);
    cmp("R3", "rdata", rdata, m_rdata);
  end

  task automatic access(bit w, bit wd, logic [7:0] a, logic [31:0] d, int gap);
    @(negedge clk);
    req = 1; we = w; wide = wd; addr = a; wdata = d;
    @(negedge clk);
    req = 0; wdata = 32'hDEAD_BEEF;
    repeat (gap) @(negedge clk);
  endtask

  task automatic do_reset(bit sa, bit sb);
    @(negedge clk);
    rst_n = 0; strap_a_n = sa; strap_b_n = sb;
    repeat (2) @(negedge clk);
    vectors++;   // reset state
    if (pin !== {!sb ? 1'b1 : gpio_out[3], !sb ? 1'b0 : gpio_out[2],
                 !sa ? 1'b1 : gpio_out[1], !sa ? 1'b0 : gpio_out[0]} || ack !== 0) begin
      errors++;
      $display("FAIL R7 reset pins actual=%b expected strap-derived", pin);
    end
    rst_n = 1;
    strap_a_n = !sa; strap_b_n = !sb;   // R7: straps ignored after reset
  endtask

  initial begin
    do_reset(0, 0);
    access(1, 0, 8'hE0, 32'h00A5_0000, 1);        // R1 byte write A
    access(1, 1, 8'hF0, 32'h1234_0000, 1);        // R1 word write B
    access(0, 1, 8'hE0, 0, 1);                    // R4 readback A
    access(0, 0, 8'hF0, 0, 1);                    // R3 byte readback B
    access(1, 0, 8'hF0, 32'h00EE_0000, 1);        // R3 byte only low
    access(0, 1, 8'hF0, 0, 1);
    access(0, 0, 8'hE1, 0, RW + 1);               // R2 R5 read strobe A
    access(0, 1, 8'hF1, 0, 0);                    // R2 read strobe B
    access(1, 1, 8'hE0, 32'h7777_0000, RW + 1);   // R9 during busy
    access(0, 1, 8'hE0, 0, 1);
    access(1, 1, 8'hE1, 32'hFFFF_0000, 1);        // R6 write to read index
    access(0, 1, 8'hE0, 0, 1);
    access(1, 1, 8'h33, 32'hFFFF_0000, 1);        // R8 other index
    access(0, 1, 8'h33, 0, 1);
    access(1, 0, 8'hE0, 32'h0011_0000, 0);        // R10 back-to-back strobes
    access(1, 0, 8'hF0, 32'h0022_0000, 0);
    access(0, 0, 8'hE1, 0, 0);
    access(0, 0, 8'hF1, 0, RW + 1);
    gpio_out = 4'b1010;
    do_reset(1, 0);                                // R7 A in GPIO mode
    access(1, 1, 8'hE0, 32'hC0DE_0000, 1);
    access(0, 1, 8'hE1, 0, 1);                    // R4 GPIO-mode read index
    gpio_out = 4'b0101;
    access(0, 0, 8'hF1, 0, RW + 1);
    do_reset(1, 1);
    access(1, 1, 8'hF0, 32'hBEEF_0000, 1);
    access(0, 1, 8'hF1, 0, 2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule